// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block lets a host processor reach a PCI-style configuration space through two registers in a small control window. The host first writes a selector register with an enable flag and the bus, device, function and dword register numbers of the target. It then reads or writes the data window, which starts exactly one configuration transaction on a simple request/response interface toward the bus logic. Byte and halfword accesses land at the data window offset plus the byte offset inside the dword. The port turns that offset into byte enables and shifted write data. On reads it shifts the returned dword down and masks it.

The host interface works as a request and a ready pulse. The host holds `hst_sel` and its qualifiers until `hst_ready` is high for one cycle. A data window access keeps the host stalled until the downstream side acknowledges, aborts, or a cycle-count timeout expires. An abort or a timeout sets a sticky error flag and returns all ones to a read.

The control is a three-state machine. `ST_IDLE` decodes a request. It takes the `IDLE->WAIT` edge for an enabled, well-formed data access and the `IDLE->RESP` edge for everything else: selector access, other offsets, disabled or malformed data access. `ST_WAIT` drives `cfg_req`. It takes `WAIT->RESP` on acknowledge, abort or timeout. `ST_RESP` raises `hst_ready` for one cycle and always takes `RESP->IDLE`.

Top module: `cfg_window_port`

## Requirements
- R1: The selector register at byte offset 0x28 holds enable in bit 31, bus number in bits 23:16, device in bits 15:11, function in bits 10:8 and dword register number in bits 7:2. It reads back exactly as last written, with bits 1:0 reading as zero, and reset clears it.
- R2: An access to the data window at 0x2C..0x2F with size 1, 2 or 4 issues one downstream transaction carrying the selector's bus, device, function and register fields. If the selector's enable bit is clear, no transaction is issued, a write is dropped, a read returns 0xFFFFFFFF and no error is reported.
- R3: `hst_size` gives the access size in bytes, and the byte offset is `hst_addr[1:0]`. Write byte enables are 4'b1111 for size 4, 4'b0011 shifted left by the offset for size 2, and 4'b0001 shifted left by the offset for size 1. Right-aligned write data is shifted left by 8 × offset.
- R4: A data read fetches a full dword and returns it shifted right by 8 × offset, masked to 8 bits for size 1 and 16 bits for size 2.
- R5: A data access whose size is not 1, 2 or 4, or whose offset is not a multiple of its size, completes with `hst_err` high and no transaction. A read in this case returns 0xFFFFFFFF.
- R6: `hst_ready` stays low while a transaction is outstanding. It rises in the cycle after the cycle in which the response is seen, and it is high for exactly one cycle.
- R7: If no response arrives within TIMEOUT cycles of request, the access completes with `hst_err`, a read returns 0xFFFFFFFF, and the sticky error flag is set. With TIMEOUT=256, ready is seen 257 cycles after the request is taken.
- R8: A downstream abort completes the access with `hst_err`, returns 0xFFFFFFFF to a read and sets the sticky error flag.
- R9: The sticky error flag, once set, stays set until reset, including across later successful accesses.
- R10: An access to any other offset reads zero, has no effect on writes, issues no transaction and completes in one cycle without error.
- R11: While `cfg_req` is high and no response has arrived, every downstream request field stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 1 | Host request, held until ready |
| hst_wr | input | 1 | Host write (1) or read (0) |
| hst_addr | input | ADDR_W | Byte address in the control window |
| hst_size | input | 3 | Access size in bytes (1, 2 or 4) |
| hst_wdata | input | 32 | Right-aligned write data |
| hst_rdata | output | 32 | Read data, valid with ready |
| hst_ready | output | 1 | One-cycle completion pulse |
| hst_err | output | 1 | Error status, valid with ready |
| cfg_err_sticky | output | 1 | Sticky timeout/abort flag |
| cfg_req | output | 1 | Downstream transaction request |
| cfg_we | output | 1 | Downstream write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 6 | Target dword register number |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Downstream completion |
| cfg_abort | input | 1 | Downstream master abort |
| cfg_rdata | input | 32 | Downstream read dword, valid with ack |

## Verification
A wrong state in the selector register shows up at once in the bus, device, function and register fields of the next transaction. It also shows up at once when the selector is read back. A wrong lane decision appears in `cfg_be` and `cfg_wdata` during the request, and in the shifted read value one cycle after the acknowledge. A timer or state fault shows as a ready pulse at the wrong cycle: too early, missing, or longer than one cycle. The directed scenarios therefore count cycles exactly: 2 plus the responder latency for a normal completion, and 257 for a timeout.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } cfgp_state_e;

    typedef struct packed {
        logic       en;
        logic [6:0] spare;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] regn;
        logic [1:0] low;
    } cfg_sel_t;

    // Legal size in bytes with an offset aligned to that size.
    function automatic logic size_ok(input logic [2:0] sz, input logic [1:0] off);
        return (sz == 3'd1) ||
               (sz == 3'd2 && !off[0]) ||
               (sz == 3'd4 && off == 2'd0);
    endfunction

endpackage

// File: rtl/cfgp_lanes.sv
module cfgp_lanes (
    input  logic [2:0]  size,
    input  logic [1:0]  off,
    input  logic [31:0] wdata_in,
    input  logic [31:0] rdword,
    output logic [3:0]  be,
    output logic [31:0] wdata_out,
    output logic [31:0] rdata_out
);
    logic [4:0]  shamt;
    logic [31:0] mask;

    always_comb begin
        shamt = {off, 3'b000};
        unique case (size)
            3'd4: begin
                be   = 4'b1111;
                mask = 32'hFFFF_FFFF;
            end
            3'd2: begin
                be   = 4'b0011 << off;
                mask = 32'h0000_FFFF;
            end
            default: begin
                be   = 4'b0001 << off;
                mask = 32'h0000_00FF;
            end
        endcase
        wdata_out = (wdata_in & mask) << shamt;
        rdata_out = (rdword >> shamt) & mask;
    end
endmodule

// File: rtl/cfgp_timer.sv
module cfgp_timer #(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port
    import cfgp_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SEL_OFS  = 8'h28,
    parameter logic [ADDR_W-1:0] DATA_OFS = 8'h2C,
    parameter int                TIMEOUT  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_sel,
    input  logic              hst_wr,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [2:0]        hst_size,
    input  logic [31:0]       hst_wdata,
    output logic [31:0]       hst_rdata,
    output logic              hst_ready,
    output logic              hst_err,
    output logic              cfg_err_sticky,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [7:0]        cfg_bus,
    output logic [4:0]        cfg_dev,
    output logic [2:0]        cfg_fn,
    output logic [5:0]        cfg_reg,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_ack,
    input  logic              cfg_abort,
    input  logic [31:0]       cfg_rdata
);
    localparam logic [ADDR_W-3:0] SEL_WORD  = SEL_OFS[ADDR_W-1:2];
    localparam logic [ADDR_W-3:0] DATA_WORD = DATA_OFS[ADDR_W-1:2];
    localparam logic [31:0]       ALL_ONES  = 32'hFFFF_FFFF;

    cfgp_state_e state_q, state_d;
    cfg_sel_t    sel_q;
    logic        we_q;
    logic [2:0]  size_q;
    logic [1:0]  off_q;
    logic [31:0] wd_q;
    logic [31:0] rdata_q;
    logic        err_q;
    logic        sticky_q;

    logic        hit_sel, hit_data, acc_ok, launch;
    logic        expired;
    logic [31:0] rd_aligned;

    assign hit_sel  = hst_addr[ADDR_W-1:2] == SEL_WORD;
    assign hit_data = hst_addr[ADDR_W-1:2] == DATA_WORD;
    assign acc_ok   = size_ok(hst_size, hst_addr[1:0]);
    assign launch   = hit_data && acc_ok && sel_q.en;

    cfgp_lanes u_lanes (
        .size      (size_q),
        .off       (off_q),
        .wdata_in  (wd_q),
        .rdword    (cfg_rdata),
        .be        (cfg_be),
        .wdata_out (cfg_wdata),
        .rdata_out (rd_aligned)
    );

    cfgp_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_WAIT),
        .expired (expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hst_sel) state_d = launch ? ST_WAIT : ST_RESP;
            ST_WAIT: if (cfg_ack || cfg_abort || expired) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Access capture and response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            we_q     <= 1'b0;
            size_q   <= 3'd4;
            off_q    <= 2'd0;
            wd_q     <= '0;
            rdata_q  <= '0;
            err_q    <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (hst_sel) begin
                        we_q   <= hst_wr;
                        size_q <= hst_size;
                        off_q  <= hst_addr[1:0];
                        wd_q   <= hst_wdata;
                        err_q  <= hit_data && !acc_ok;
                        if (hit_sel) begin
                            rdata_q <= sel_q;
                            if (hst_wr) sel_q <= {hst_wdata[31:2], 2'b00};
                        end else if (hit_data) begin
                            rdata_q <= ALL_ONES;
                        end else begin
                            rdata_q <= '0;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cfg_abort || (!cfg_ack && expired)) begin
                        rdata_q  <= ALL_ONES;
                        err_q    <= 1'b1;
                        sticky_q <= 1'b1;
                    end else if (cfg_ack) begin
                        rdata_q <= rd_aligned;
                        err_q   <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        hst_ready      = (state_q == ST_RESP);
        hst_err        = hst_ready && err_q;
        hst_rdata      = rdata_q;
        cfg_err_sticky = sticky_q;
        cfg_req        = (state_q == ST_WAIT);
        cfg_we         = we_q;
        cfg_bus        = sel_q.bus;
        cfg_dev        = sel_q.dev;
        cfg_fn         = sel_q.fn;
        cfg_reg        = sel_q.regn;
    end
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DATA_OFS = 8'h2C,
    parameter int                TIMEOUT  = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_sel,
    input logic [ADDR_W-1:0] hst_addr,
    input logic              hst_ready,
    input logic              cfg_err_sticky,
    input logic              cfg_req,
    input logic              cfg_we,
    input logic [7:0]        cfg_bus,
    input logic [4:0]        cfg_dev,
    input logic [2:0]        cfg_fn,
    input logic [5:0]        cfg_reg,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic              cfg_ack,
    input logic              cfg_abort
);
    localparam int CW = $clog2(TIMEOUT + 1) + 1;
    logic [CW-1:0] req_cycles;

    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_req) req_cycles <= '0;
        else                    req_cycles <= req_cycles + 1'b1;
    end

    // R2
    req_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> $past(hst_sel) && ($past(hst_addr[ADDR_W-1:2]) == DATA_OFS[ADDR_W-1:2]));

    // R3
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111}));

    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ready |=> !hst_ready);

    // R6
    resp_to_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && (cfg_ack || cfg_abort) |=> hst_ready && !cfg_req);

    // R7
    req_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> req_cycles < CW'(TIMEOUT));

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_sticky |=> cfg_err_sticky);

    // R11
    fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack && !cfg_abort |=> !cfg_req ||
            $stable({cfg_we, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_be, cfg_wdata}));
endmodule

bind cfg_window_port cfgp_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_OFS (DATA_OFS),
    .TIMEOUT  (TIMEOUT)
) u_cfgp_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hst_sel        (hst_sel),
    .hst_addr       (hst_addr),
    .hst_ready      (hst_ready),
    .cfg_err_sticky (cfg_err_sticky),
    .cfg_req        (cfg_req),
    .cfg_we         (cfg_we),
    .cfg_bus        (cfg_bus),
    .cfg_dev        (cfg_dev),
    .cfg_fn         (cfg_fn),
    .cfg_reg        (cfg_reg),
    .cfg_be         (cfg_be),
    .cfg_wdata      (cfg_wdata),
    .cfg_ack        (cfg_ack),
    .cfg_abort      (cfg_abort)
);

// File: tb/test_cfg_window_port.sv
module test_cfg_window_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_sel = 1'b0, hst_wr = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic [2:0]  hst_size = 3'd4;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        hst_ready, hst_err, cfg_err_sticky;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0, cfg_abort = 1'b0;
    logic [31:0] cfg_rdata = '0;

    always #2 clk = ~clk;

    cfg_window_port i_cfg_window_port (.*);

    int n_chk = 0, n_err = 0;

    // Downstream responder: mode 0 ack, 1 abort, 2 silent
    int          rmode = 0, rlat = 0, wait_cnt = 0, txn_cnt = 0, drift = 0;
    logic        prev_req = 1'b0;
    logic [31:0] mem [0:63];
    logic [7:0]  l_bus; logic [4:0] l_dev; logic [2:0] l_fn; logic [5:0] l_reg;
    logic [3:0]  l_be;  logic l_we; logic [31:0] l_wd;

    always @(negedge clk) begin
        if (cfg_req && !prev_req) begin
            txn_cnt++;
            l_bus = cfg_bus; l_dev = cfg_dev; l_fn = cfg_fn; l_reg = cfg_reg;
            l_be = cfg_be; l_we = cfg_we; l_wd = cfg_wdata;
        end
        prev_req = cfg_req;
        if (cfg_req && !cfg_ack && !cfg_abort) begin
            if ({cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_be, cfg_we, cfg_wdata} !==
                {l_bus, l_dev, l_fn, l_reg, l_be, l_we, l_wd}) drift++;
            if (rmode != 2 && wait_cnt >= rlat) begin
                if (rmode == 0) begin
                    if (cfg_we)
                        for (int i = 0; i < 4; i++)
                            if (cfg_be[i]) mem[cfg_reg][8*i +: 8] = cfg_wdata[8*i +: 8];
                    cfg_rdata = mem[cfg_reg];
                    cfg_ack = 1'b1;
                end else begin
                    cfg_rdata = 32'h0BAD_0BAD;
                    cfg_abort = 1'b1;
                end
            end else begin
                wait_cnt++;
            end
        end else if (!cfg_req) begin
            cfg_ack = 1'b0; cfg_abort = 1'b0; wait_cnt = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [7:0] a, input logic [2:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd,
                       output logic er, output int cyc);
        @(negedge clk);
        hst_sel = 1'b1; hst_wr = wr; hst_addr = a; hst_size = sz; hst_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!hst_ready && cyc < 1000);
        rd = hst_rdata; er = hst_err;
        hst_sel = 1'b0;
        if (!hst_ready) check("R6 ready never seen", 32'd0, 32'd1);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    localparam logic [31:0] SEL_V = 32'h8012_AD14; // en, bus 12, dev 15, fn 5, reg 5

    task automatic t_reset();
        logic [31:0] rd; logic er; int c;
        check("R6 ready low after reset", hst_ready, 0);
        check("R2 no request after reset", cfg_req, 0);
        check("R9 sticky clear after reset", cfg_err_sticky, 0);
        acc(0, 8'h28, 4, 0, rd, er, c);
        check("R1 selector reset value", rd, 0);
    endtask

    task automatic t_selector();
        logic [31:0] rd; logic er; int c;
        acc(1, 8'h28, 4, 32'h7FFF_FFFF, rd, er, c);
        acc(0, 8'h28, 4, 0, rd, er, c);
        check("R1 readback low bits zero", rd, 32'h7FFF_FFFC);
        acc(1, 8'h28, 4, SEL_V | 32'h3, rd, er, c);
        acc(0, 8'h28, 4, 0, rd, er, c);
        check("R1 readback fields", rd, SEL_V);
        check("R10 selector access issues nothing", txn_cnt, 0);
    endtask

    task automatic t_dword();
        logic [31:0] rd; logic er; int c;
        acc(1, 8'h2C, 4, 32'hDEAD_BEEF, rd, er, c);
        check("R2 one transaction", txn_cnt, 1);
        check("R2 fields bus/dev/fn/reg", {l_bus, 3'b0, l_dev, 5'b0, l_fn, 2'b0, l_reg},
              {8'h12, 3'b0, 5'h15, 5'b0, 3'd5, 2'b0, 6'd5});
        check("R3 dword be", l_be, 4'hF);
        check("R2 write flag", l_we, 1);
        check("R2 dword stored", mem[5], 32'hDEAD_BEEF);
        check("R2 no error", er, 0);
        acc(0, 8'h2C, 4, 0, rd, er, c);
        check("R4 dword read", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_subword();
        logic [31:0] rd; logic er; int c;
        acc(1, 8'h2E, 1, 32'hFFFF_FF5A, rd, er, c);
        check("R3 byte be at offset 2", l_be, 4'b0100);
        check("R3 byte data lane", l_wd[23:16], 8'h5A);
        check("R3 byte merge", mem[5], 32'hDE5A_BEEF);
        acc(1, 8'h2E, 2, 32'h0000_1234, rd, er, c);
        check("R3 halfword be at offset 2", l_be, 4'b1100);
        check("R3 halfword merge", mem[5], 32'h1234_BEEF);
        acc(1, 8'h2D, 1, 32'h0000_0077, rd, er, c);
        check("R3 byte be at offset 1", l_be, 4'b0010);
        acc(0, 8'h2D, 1, 0, rd, er, c);
        check("R4 byte read offset 1", rd, 32'h0000_0077);
        acc(0, 8'h2E, 2, 0, rd, er, c);
        check("R4 halfword read offset 2", rd, 32'h0000_1234);
        acc(0, 8'h2F, 1, 0, rd, er, c);
        check("R4 byte read offset 3", rd, 32'h0000_0012);
        acc(0, 8'h2C, 2, 0, rd, er, c);
        check("R4 halfword read offset 0", rd, 32'h0000_77EF);
    endtask

    task automatic t_disabled();
        logic [31:0] rd; logic er; int c, t0;
        acc(1, 8'h28, 4, SEL_V & 32'h7FFF_FFFF, rd, er, c);
        t0 = txn_cnt;
        acc(1, 8'h2C, 4, 32'h0, rd, er, c);
        check("R2 disabled write no error", er, 0);
        acc(0, 8'h2C, 4, 0, rd, er, c);
        check("R2 disabled read ones", rd, 32'hFFFF_FFFF);
        check("R2 disabled no transaction", txn_cnt, t0);
        acc(1, 8'h28, 4, SEL_V, rd, er, c);
        acc(0, 8'h2C, 4, 0, rd, er, c);
        check("R2 disabled write dropped", rd, 32'h1234_77EF);
    endtask

    task automatic t_badsize();
        logic [31:0] rd; logic er; int c, t0;
        t0 = txn_cnt;
        acc(0, 8'h2C, 3, 0, rd, er, c);
        check("R5 size 3 error", er, 1);
        check("R5 size 3 reads ones", rd, 32'hFFFF_FFFF);
        acc(1, 8'h2D, 2, 32'h1, rd, er, c);
        check("R5 misaligned halfword error", er, 1);
        acc(1, 8'h2E, 4, 32'h1, rd, er, c);
        check("R5 misaligned dword error", er, 1);
        check("R5 no transaction", txn_cnt, t0);
        check("R5 sticky untouched", cfg_err_sticky, 0);
    endtask

    task automatic t_latency();
        logic [31:0] rd; logic er; int c;
        rlat = 5; drift = 0;
        acc(0, 8'h2C, 4, 0, rd, er, c);
        check("R6 ready after latency+2", c, 7);
        check("R11 fields stable while waiting", drift, 0);
        @(negedge clk);
        check("R6 ready one cycle", hst_ready, 0);
        rlat = 0;
    endtask

    task automatic t_other();
        logic [31:0] rd; logic er; int c, t0;
        t0 = txn_cnt;
        acc(1, 8'h10, 4, 32'hCAFE_F00D, rd, er, c);
        check("R10 other write one cycle", c, 1);
        acc(0, 8'h10, 4, 0, rd, er, c);
        check("R10 other read zero", rd, 0);
        check("R10 other no error", er, 0);
        check("R10 other no transaction", txn_cnt, t0);
        acc(0, 8'h28, 4, 0, rd, er, c);
        check("R10 selector unchanged", rd, SEL_V);
    endtask

    task automatic t_abort();
        logic [31:0] rd; logic er; int c;
        rmode = 1;
        acc(0, 8'h2E, 2, 0, rd, er, c);
        check("R8 abort error", er, 1);
        check("R8 abort reads ones", rd, 32'hFFFF_FFFF);
        check("R8 sticky set", cfg_err_sticky, 1);
        rmode = 0;
        acc(0, 8'h2C, 4, 0, rd, er, c);
        check("R9 good access no error", er, 0);
        check("R9 sticky held", cfg_err_sticky, 1);
    endtask

    task automatic t_timeout();
        logic [31:0] rd; logic er; int c;
        do_reset();
        check("R9 sticky cleared by reset", cfg_err_sticky, 0);
        acc(0, 8'h28, 4, 0, rd, er, c);
        check("R1 selector cleared by reset", rd, 0);
        acc(1, 8'h28, 4, SEL_V, rd, er, c);
        rmode = 2;
        acc(0, 8'h2C, 4, 0, rd, er, c);
        check("R7 timeout cycle count", c, 257);
        check("R7 timeout error", er, 1);
        check("R7 timeout reads ones", rd, 32'hFFFF_FFFF);
        check("R7 sticky set", cfg_err_sticky, 1);
        rmode = 0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 | i;
        do_reset();
        t_reset();
        t_selector();
        t_dword();
        t_subword();
        t_disabled();
        t_badsize();
        t_latency();
        t_other();
        t_abort();
        t_timeout();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule